// File: doc/BRIEF.md
# Frame-Synchronous ISDN Serial Port

This block is the framed serial side of a time-division ISDN link. It runs on the system clock and oversamples three line inputs: a bit clock, an 8 kHz frame strobe and a receive data line. It drives one output, a transmit data line. Every bit lasts two bit-clock cycles. A rising edge of the strobe, seen on a rising bit-clock edge, opens a frame. The frame holds 32 bits in 64 bit-clock cycles, sent as four octets: user channel 1, user channel 2, a monitor octet, and a control octet. The control octet carries two D-channel bits, a 4-bit command/indication code and the MR and MX handshake bits.

Transmit words arrive on a valid/ready stream. The port raises `tx_ready` for one system clock at each frame start and takes `tx_frame` if `tx_valid` is high in that cycle. This is the only point where back-pressure acts. A source must hold `tx_valid` and `tx_frame` steady until it sees `tx_ready`. If no word is offered at a frame start, that frame goes out as all ones. Received frames leave on a valid-only stream: `rx_valid` pulses for one cycle with the whole word on `rx_frame`. The serial line cannot stall, so the sink must take each word on that pulse.

`port_en` turns all line activity on and off. While it is low, the transmit line rests high and nothing is captured or requested.

Top module: `isdn_frame_port`

## Requirements
- R1: A frame starts only when the strobe is seen high on a rising bit-clock edge after it was seen low on the previous rising edge, and only while `port_en` is high. A strobe held high for several cycles does not restart the frame.
- R2: `ser_tx` carries the loaded word MSB first, starting with bit 31. The word layout is [31:24] user channel 1, [23:16] user channel 2, [15:8] monitor, [7:6] D bits, [5:2] command/indication code, [1] MR, [0] MX.
- R3: Each transmit bit changes on the rising bit-clock edge that opens the first of its two cycles and holds for both cycles. Bit k occupies frame cycles 2k and 2k+1.
- R4: Each received bit is sampled on the falling bit-clock edge in the second cycle of its bit period. The bits are assembled MSB first into the same layout as R2.
- R5: After the last bit of a complete frame is sampled, `rx_valid` pulses for exactly one clock with the frame on `rx_frame`. `rx_frame` keeps its value at all other times.
- R6: `tx_ready` pulses for one clock at each frame start, and the word on `tx_frame` is taken only when `tx_valid` is high in that cycle.
- R7: A frame that starts without `tx_valid` sends all ones.
- R8: A strobe rising edge before the 64th cycle restarts the frame at cycle 0. The new word is loaded, and the partially received frame is dropped with no `rx_valid`.
- R9: If no strobe edge follows the 64th cycle, `ser_tx` stays high and nothing is captured until the next strobe edge.
- R10: When `port_en` is low, `ser_tx` is high from the next clock, and neither `tx_ready` nor `rx_valid` is raised. After `port_en` returns high, the port waits for a new strobe edge.
- R11: After reset, `ser_tx` is 1, `tx_ready` and `rx_valid` are 0, and `rx_frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Enables line activity |
| bit_clk | input | 1 | Line data clock at twice the bit rate |
| frame_strobe | input | 1 | 8 kHz frame strobe |
| ser_rx | input | 1 | Serial receive data |
| ser_tx | output | 1 | Serial transmit data, idles high |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Frame start, the offered word is taken |
| tx_frame | input | 32 | Transmit word in the R2 layout |
| rx_valid | output | 1 | One-cycle pulse, received word ready |
| rx_frame | output | 32 | Last complete received word |

## Verification
Random transmit and receive words, with strobe pulses of random length, test bit order and two-cycle bit timing across many values. They also show that a long strobe does not reframe the port. A directed frame with a distinct value in each field confirms the octet and control-field layout. A short frame followed by a full frame separates a correct resync from one that leaks stale bits. It also shows whether a partial frame gets reported. Frames without a word, spans with no strobe, and disabled spans, including a disable in mid-frame and a re-enable with no strobe, show that the line rests high and that no handshake or capture happens when it should not.

// File: rtl/isdn_port_pkg.sv
package isdn_port_pkg;
  localparam int DEF_SLOTS       = 4;
  localparam int DEF_SLOT_BITS   = 8;
  localparam int DEF_CYC_PER_BIT = 2;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/isdn_port_sync.sv
module isdn_port_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/isdn_port_timing.sv
module isdn_port_timing
  import isdn_port_pkg::*;
#(
  parameter int FRAME_BITS  = 32,
  parameter int CYC_PER_BIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk_s,
  input  logic strobe_s,
  output logic load_ev,
  output logic shift_ev,
  output logic stop_ev,
  output logic sample_ev,
  output logic last_ev,
  output logic running
);
  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int PW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [PW-1:0] LAST_PH  = PW'(CYC_PER_BIT - 1);

  logic          bclk_q;
  logic          strobe_prev;
  phase_e        phase;
  logic [BW-1:0] bitn;
  logic [PW-1:0] ph;

  logic rise, fall, act, last_ph, last_bit;

  always_comb begin
    rise      = bclk_s & ~bclk_q;
    fall      = ~bclk_s & bclk_q;
    act       = (phase == PH_RUN) & en;
    last_ph   = (ph == LAST_PH);
    last_bit  = (bitn == LAST_BIT);
    load_ev   = rise & strobe_s & ~strobe_prev & en;
    shift_ev  = rise & act & ~load_ev & last_ph & ~last_bit;
    stop_ev   = rise & act & ~load_ev & last_ph & last_bit;
    sample_ev = fall & act & last_ph;
    last_ev   = sample_ev & last_bit;
    running   = (phase == PH_RUN);
  end

  // Edge history of the bit clock and strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q      <= 1'b0;
      strobe_prev <= 1'b0;
    end else begin
      bclk_q <= bclk_s;
      if (rise) strobe_prev <= strobe_s;
    end
  end

  // Bit and phase position within the frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      bitn  <= '0;
      ph    <= '0;
    end else if (!en) begin
      phase <= PH_IDLE;
      bitn  <= '0;
      ph    <= '0;
    end else if (load_ev) begin
      phase <= PH_RUN;
      bitn  <= '0;
      ph    <= '0;
    end else if (rise && phase == PH_RUN) begin
      if (last_ph) begin
        ph <= '0;
        if (last_bit) phase <= PH_IDLE;
        else          bitn  <= bitn + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/isdn_port_tx.sv
module isdn_port_tx #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  load_ev,
  input  logic                  shift_ev,
  input  logic                  stop_ev,
  input  logic                  word_valid,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  line
);
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      line  <= 1'b1;
    end else if (!en) begin
      shreg <= '1;
      line  <= 1'b1;
    end else if (load_ev) begin
      if (word_valid) begin
        line  <= word[FRAME_BITS-1];
        shreg <= {word[FRAME_BITS-2:0], 1'b1};
      end else begin
        line  <= 1'b1;
        shreg <= '1;
      end
    end else if (shift_ev) begin
      line  <= shreg[FRAME_BITS-1];
      shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
    end else if (stop_ev) begin
      line <= 1'b1;
    end
  end
endmodule

// File: rtl/isdn_port_rx.sv
module isdn_port_rx #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_ev,
  input  logic                  last_ev,
  input  logic                  bit_in,
  output logic [FRAME_BITS-1:0] frame_q,
  output logic                  frame_vld
);
  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] next_sh;

  assign next_sh = {shreg[FRAME_BITS-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      frame_q   <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= 1'b0;
      if (sample_ev) shreg <= next_sh;
      if (last_ev) begin
        frame_q   <= next_sh;
        frame_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isdn_frame_port.sv
module isdn_frame_port
  import isdn_port_pkg::*;
#(
  parameter int NUM_SLOTS   = DEF_SLOTS,
  parameter int SLOT_BITS   = DEF_SLOT_BITS,
  parameter int CYC_PER_BIT = DEF_CYC_PER_BIT,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           port_en,
  input  logic                           bit_clk,
  input  logic                           frame_strobe,
  input  logic                           ser_rx,
  output logic                           ser_tx,
  input  logic                           tx_valid,
  output logic                           tx_ready,
  input  logic [NUM_SLOTS*SLOT_BITS-1:0] tx_frame,
  output logic                           rx_valid,
  output logic [NUM_SLOTS*SLOT_BITS-1:0] rx_frame
);
  localparam int FRAME_BITS = NUM_SLOTS * SLOT_BITS;

  logic [2:0] line_raw, line_s;
  logic bclk_s, strobe_s, rxd_s;
  logic load_ev, shift_ev, stop_ev, sample_ev, last_ev, frame_run;

  assign line_raw = {bit_clk, frame_strobe, ser_rx};
  assign {bclk_s, strobe_s, rxd_s} = line_s;

  isdn_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_raw), .q(line_s)
  );

  isdn_port_timing #(.FRAME_BITS(FRAME_BITS), .CYC_PER_BIT(CYC_PER_BIT)) u_tim (
    .clk(clk), .rst_n(rst_n), .en(port_en),
    .bclk_s(bclk_s), .strobe_s(strobe_s),
    .load_ev(load_ev), .shift_ev(shift_ev), .stop_ev(stop_ev),
    .sample_ev(sample_ev), .last_ev(last_ev), .running(frame_run)
  );

  isdn_port_tx #(.FRAME_BITS(FRAME_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(port_en),
    .load_ev(load_ev), .shift_ev(shift_ev), .stop_ev(stop_ev),
    .word_valid(tx_valid), .word(tx_frame), .line(ser_tx)
  );

  isdn_port_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample_ev(sample_ev), .last_ev(last_ev),
    .bit_in(rxd_s), .frame_q(rx_frame), .frame_vld(rx_valid)
  );

  assign tx_ready = load_ev;
endmodule

// File: rtl/isdn_frame_port_chk.sv
module isdn_frame_port_chk #(
  parameter int FB = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          ser_tx,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic [FB-1:0] rx_frame,
  input logic          frame_run
);
  p_rx_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_frame));

  p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  p_idle_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_run && !tx_ready) |=> ser_tx);

  p_off_line_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> ser_tx);

  p_off_no_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !tx_ready);

  p_off_no_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !rx_valid);
endmodule

bind isdn_frame_port isdn_frame_port_chk #(.FB(NUM_SLOTS*SLOT_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .ser_tx(ser_tx),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_frame(rx_frame),
  .frame_run(frame_run)
);

// File: tb/isdn_frame_port_test.sv
`timescale 1ns/1ps
module isdn_frame_port_test;
  localparam int HALF = 8;
  localparam int FB   = 32;

  logic clk = 1'b0, rst_n = 1'b0, port_en = 1'b0;
  logic bit_clk = 1'b0, frame_strobe = 1'b0, ser_rx = 1'b1, tx_valid = 1'b0;
  logic [FB-1:0] tx_frame = '0;
  logic ser_tx, tx_ready, rx_valid;
  logic [FB-1:0] rx_frame;

  int errors = 0, checks = 0, rx_cnt = 0, acc_cnt = 0;
  logic [FB-1:0] rx_last = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  isdn_frame_port uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .bit_clk(bit_clk),
    .frame_strobe(frame_strobe), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_frame(tx_frame),
    .rx_valid(rx_valid), .rx_frame(rx_frame)
  );

  always @(posedge clk) begin
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      rx_last <= rx_frame;
    end
    if (tx_valid && tx_ready) acc_cnt <= acc_cnt + 1;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [FB-1:0] act, input logic [FB-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 layout builder
  function automatic logic [FB-1:0] pack_frame(logic [7:0] u1, logic [7:0] u2,
      logic [7:0] mon, logic [1:0] d, logic [3:0] ci, logic mr, logic mx);
    return {u1, u2, mon, d, ci, mr, mx};
  endfunction

  // R2/R3/R7/R9: expected line level in frame cycle c
  function automatic logic exp_line(logic [FB-1:0] w, bit loaded, int c);
    if (!loaded || c >= 2*FB) return 1'b1;
    return w[FB-1-c/2];
  endfunction

  task automatic span(input int ncyc, input int strobe_len, input logic [FB-1:0] rxw,
                      input bit loaded, input logic [FB-1:0] txw,
                      input int exp_rx, input int exp_acc, input string tag);
    int rx0, a0;
    logic e;
    rx0 = rx_cnt;
    a0  = acc_cnt;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      bit_clk      = 1'b1;
      frame_strobe = (c < strobe_len);
      ser_rx       = (c < 2*FB) ? rxw[FB-1-c/2] : 1'b1;
      repeat (HALF) @(negedge clk);
      e = exp_line(txw, loaded, c);
      check(ser_tx === e, tag, {31'd0, ser_tx}, {31'd0, e});
      bit_clk = 1'b0;
      repeat (HALF-1) @(negedge clk);
      e = exp_line(txw, loaded, c);
      check(ser_tx === e, tag, {31'd0, ser_tx}, {31'd0, e});
    end
    check(rx_cnt - rx0 == exp_rx, {tag, " R5 rx count"}, FB'(rx_cnt - rx0), FB'(exp_rx));
    check(acc_cnt - a0 == exp_acc, {tag, " R6 accepts"}, FB'(acc_cnt - a0), FB'(exp_acc));
    if (exp_rx > 0) check(rx_last === rxw, {tag, " R4 rx word"}, rx_last, rxw);
  endtask

  initial begin
    logic [FB-1:0] tw, rw, rw2;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R11 reset state
    check(ser_tx === 1'b1, "R11 ser_tx", {31'd0, ser_tx}, 32'd1);
    check(tx_ready === 1'b0, "R11 tx_ready", {31'd0, tx_ready}, 32'd0);
    check(rx_valid === 1'b0, "R11 rx_valid", {31'd0, rx_valid}, 32'd0);
    check(rx_frame === '0, "R11 rx_frame", rx_frame, 32'd0);
    rst_n = 1'b1;
    port_en = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R4 directed field layout
    tw = pack_frame(8'hA5, 8'h3C, 8'hF0, 2'b10, 4'b0110, 1'b1, 1'b0);
    rw = pack_frame(8'h5A, 8'hC3, 8'h0F, 2'b01, 4'b1001, 1'b0, 1'b1);
    tx_frame = tw; tx_valid = 1'b1;
    span(64, 2, rw, 1, tw, 1, 1, "R2");

    // R1 R3 random words, long strobe pulses
    for (int k = 0; k < 8; k++) begin
      tw = $urandom; rw = $urandom;
      tx_frame = tw; tx_valid = 1'b1;
      span(64, 1 + int'($urandom % 12), rw, 1, tw, 1, 1, "R1/R3");
    end

    // R7 no word offered
    tx_valid = 1'b0; tx_frame = 32'h0000_0000; rw = $urandom;
    span(64, 2, rw, 0, tx_frame, 1, 0, "R7");

    // R8 early strobe resync
    tw = $urandom; rw = $urandom; tx_frame = tw; tx_valid = 1'b1;
    span(40, 2, rw, 1, tw, 0, 1, "R8 short");
    tw = $urandom; rw2 = $urandom; tx_frame = tw;
    span(64, 2, rw2, 1, tw, 1, 1, "R8 restart");

    // R9 missing strobe
    tw = $urandom; rw = $urandom; tx_frame = tw;
    span(64, 2, rw, 1, tw, 1, 1, "R9 frame");
    span(24, 0, $urandom, 0, tw, 0, 0, "R9 gap");

    // R10 disable mid-frame, disabled frame, re-enable without strobe
    tw = 32'h0000_0000; tx_frame = tw;
    span(10, 2, $urandom, 1, tw, 0, 1, "R10 pre");
    @(negedge clk); port_en = 1'b0;
    repeat (2) @(negedge clk);
    check(ser_tx === 1'b1, "R10 mid-frame off", {31'd0, ser_tx}, 32'd1);
    span(64, 2, $urandom, 0, tw, 0, 0, "R10 off");
    port_en = 1'b1;
    span(30, 0, $urandom, 0, tw, 0, 0, "R10 wait");
    tw = $urandom; rw = $urandom; tx_frame = tw;
    span(64, 2, rw, 1, tw, 1, 1, "R10 resume");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule